// File: doc/BRIEF.md
# Five-Channel Timer Tick Prescaler Tree

This block produces the count-enable ticks that drive the five down-counters of a PWM timer, all from one system clock. Two shared 8-bit prescalers divide the system clock by a programmable amount. The first prescaler serves channels 0 and 1. The second serves channels 2, 3 and 4. Each channel then divides its prescaler's pulse train again by 2, 4, 8 or 16. It can instead take its ticks from the rising edges of an external clock pin, which is shared by the same channel groups. Every output is a one-cycle enable pulse in the system clock domain. No derived or gated clock is produced.

Configuration comes through a plain write port. One address takes both prescaler values as a single word. Another takes all five channel fields at once. Five further addresses each write a single channel's 4-bit field, and the hardware merges it into the channel word without touching the other channels. Each 4-bit field holds both the divider choice and the external-clock choice, so selecting the external clock replaces the divider setting. Any write reloads the counters it affects, so the new ratio starts from a clean period.

Top module: `tick_prescaler_tree`

## Requirements
- R1: After synchronous active-high reset, all fields are zero and every tick output is low during reset. Once reset is released, each channel ticks every 2 cycles (prescaler ratio 1, channel divider 2).
- R2: A prescaler field value N makes its prescaler pulse once every N+1 system cycles, for N from 0 to 255. A channel with divider D therefore ticks every D*(N+1) cycles.
- R3: The prescaler word is written at address 0. Bits [7:0] set the prescaler for channels 0 and 1. Bits [15:8] set the prescaler for channels 2, 3 and 4.
- R4: The channel word is written at address 1. Channel c uses bits [4c+3:4c]. Field codes 0, 1, 2 and 3 select division of the prescaler pulses by 2, 4, 8 and 16.
- R5: A channel field of 4 or more selects the external clock. The channel then ticks exactly once per rising edge of its external input and ignores its prescaler. Input 0 serves channels 0 and 1. Input 1 serves channels 2, 3 and 4.
- R6: Writing address 2+c replaces only channel c's field with wr_data[3:0]. The other channels' fields are left unchanged.
- R7: A write to the prescaler word restarts both prescalers and all channel dividers. If the write is presented in cycle t, a divide-by-2 channel on prescaler value N first ticks in cycle t+2(N+1).
- R8: A write to a channel's field clears only that channel's divider count. With a prescaler ratio of 1 and divider D, the first tick comes D cycles after the write cycle.
- R9: A tick is never high on two consecutive cycles, except across a write that changes the channel's configuration.
- R10: A write to any address of 2+5 or higher (7 for the default parameters) changes no configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 3 | 0 = prescaler word, 1 = channel word, 2+c = single field of channel c |
| wr_data | input | 20 | Write data; field writes use bits [3:0] |
| ext_clk | input | 2 | External clock inputs: [0] for channels 0-1, [1] for channels 2-4 |
| tick | output | 5 | One-cycle count-enable pulse per channel |

## Verification
The bench measures tick periods under several prescaler values (0, 3, 9, 4 and the extreme 255) combined with every divider code. Using different values for the two prescalers shows whether a channel is wired to the wrong group. Latency from a write to the first tick separates a true counter reload from a stale partial period. Single-field writes and unmapped writes are followed by period checks on the untouched channels, which would reveal a clobbered field. External edges are sent on one input at a time, and the bench counts ticks on every external-mode channel, which exposes cross-wired inputs, dropped edges or double ticks.

// File: rtl/tick_tree_pkg.sv
package tick_tree_pkg;

    localparam int unsigned FIELD_W   = 4;
    localparam int unsigned DIV_CNT_W = 4;
    localparam int unsigned NUM_GROUPS = 2;

    localparam int unsigned ADDR_PSC_WORD = 0;
    localparam int unsigned ADDR_CH_WORD  = 1;
    localparam int unsigned ADDR_FIELD0   = 2;

    // Field codes of 4 and above hand the channel to its external clock.
    function automatic logic field_is_ext(input logic [FIELD_W-1:0] f);
        return |f[FIELD_W-1:2];
    endfunction

    // Terminal count of the channel divider: ratio minus one.
    function automatic logic [DIV_CNT_W-1:0] field_last(input logic [FIELD_W-1:0] f);
        logic [DIV_CNT_W-1:0] r;
        case (f[1:0])
            2'd0:    r = 4'd1;
            2'd1:    r = 4'd3;
            2'd2:    r = 4'd7;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/psc_counter.sv
module psc_counter #(
    parameter int unsigned PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [PSC_W-1:0] ratio_m1,
    output logic             pulse
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        pulse = (st_q.cnt == ratio_m1);
        if (reload) begin
            st_d.cnt = '0;
        end else if (pulse) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2: the count never runs past the programmed terminal value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= ratio_m1)
        else $error("prescaler count beyond terminal value");

endmodule

// File: rtl/ext_edge_sync.sv
module ext_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic rise
);

    localparam int unsigned SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.sh = {st_q.sh[SH_W-2:0], ext_in};
        rise    = st_q.sh[SYNC_STAGES-1] & ~st_q.sh[SYNC_STAGES];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R9: an edge is reported for one cycle only
    p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise)
        else $error("edge detector held high two cycles");

endmodule

// File: rtl/chan_divider.sv
module chan_divider
    import tick_tree_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [FIELD_W-1:0] field,
    input  logic               psc_pulse,
    input  logic               ext_rise,
    output logic               tick
);

    typedef struct packed {
        logic [DIV_CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic                 use_ext;
    logic [DIV_CNT_W-1:0] last;
    logic                 at_last;

    always_comb begin
        use_ext = field_is_ext(field);
        last    = field_last(field);
        at_last = (st_q.cnt == last);
        st_d    = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (!use_ext && psc_pulse) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
        end
        tick = use_ext ? ext_rise : (psc_pulse && at_last);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4: divider count stays inside the selected ratio
    p_div_bound_r4: assert property (@(posedge clk) disable iff (rst)
        !use_ext |-> (st_q.cnt <= last))
        else $error("channel divider count out of range");

    // R5: in external mode nothing but a synchronized edge makes a tick
    p_ext_only_r5: assert property (@(posedge clk) disable iff (rst)
        (use_ext && !ext_rise) |-> !tick)
        else $error("tick in external mode without an edge");

    // R9: no back-to-back ticks unless the configuration was just rewritten
    p_tick_single_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> !tick)
        else $error("channel tick held two cycles");

endmodule

// File: rtl/tick_prescaler_tree.sv
module tick_prescaler_tree
    import tick_tree_pkg::*;
#(
    parameter int unsigned NUM_CH        = 5,
    parameter int unsigned PSC_W         = 8,
    parameter int unsigned GROUP1_FIRST  = 2,
    parameter int unsigned ADDR_W        = 3,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [((NUM_CH*FIELD_W) > (NUM_GROUPS*PSC_W) ? (NUM_CH*FIELD_W) : (NUM_GROUPS*PSC_W))-1:0] wr_data,
    input  logic [NUM_GROUPS-1:0] ext_clk,
    output logic [NUM_CH-1:0]   tick
);

    localparam int unsigned CH_WORD_W  = NUM_CH * FIELD_W;
    localparam int unsigned PSC_WORD_W = NUM_GROUPS * PSC_W;
    localparam int unsigned FIRST_UNMAPPED = ADDR_FIELD0 + NUM_CH;

    typedef struct packed {
        logic [PSC_WORD_W-1:0] psc_word;
        logic [CH_WORD_W-1:0]  ch_word;
    } cfg_t;

    cfg_t                  cfg_d, cfg_q;
    logic                  psc_reload;
    logic [NUM_CH-1:0]     ch_clr;
    logic [NUM_GROUPS-1:0] psc_pulse;
    logic [NUM_GROUPS-1:0] ext_rise;

    // Write decode and per-field read-modify-write merge.
    always_comb begin
        cfg_d      = cfg_q;
        psc_reload = 1'b0;
        ch_clr     = '0;
        if (wr_en) begin
            if (int'(wr_addr) == ADDR_PSC_WORD) begin
                cfg_d.psc_word = wr_data[PSC_WORD_W-1:0];
                psc_reload     = 1'b1;
                ch_clr         = '1;
            end else if (int'(wr_addr) == ADDR_CH_WORD) begin
                cfg_d.ch_word = wr_data[CH_WORD_W-1:0];
                ch_clr        = '1;
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (int'(wr_addr) == ADDR_FIELD0 + i) begin
                        cfg_d.ch_word[i*FIELD_W +: FIELD_W] = wr_data[FIELD_W-1:0];
                        ch_clr[i] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    // Shared prescalers and external-edge detectors, one per group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        psc_counter #(.PSC_W(PSC_W)) u_psc (
            .clk      (clk),
            .rst      (rst),
            .reload   (psc_reload),
            .ratio_m1 (cfg_q.psc_word[g*PSC_W +: PSC_W]),
            .pulse    (psc_pulse[g])
        );

        ext_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .ext_in (ext_clk[g]),
            .rise   (ext_rise[g])
        );
    end

    // Per-channel divider / source select.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam int unsigned GRP = (c >= GROUP1_FIRST) ? 1 : 0;
        localparam logic [CH_WORD_W-1:0] OWN_MASK =
            {{(CH_WORD_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << (c*FIELD_W);

        chan_divider u_div (
            .clk       (clk),
            .rst       (rst),
            .clr       (ch_clr[c]),
            .field     (cfg_q.ch_word[c*FIELD_W +: FIELD_W]),
            .psc_pulse (psc_pulse[GRP]),
            .ext_rise  (ext_rise[GRP]),
            .tick      (tick[c])
        );

        // R6: a single-field write leaves every other field as it was
        p_field_isolation_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_en && int'(wr_addr) == ADDR_FIELD0 + c) |=>
                (((cfg_q.ch_word ^ $past(cfg_q.ch_word)) & ~OWN_MASK) == '0))
            else $error("field write disturbed another channel");
    end

    // R10: writes above the field range change nothing
    p_unmapped_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) >= FIRST_UNMAPPED) |=> $stable(cfg_q))
        else $error("unmapped write altered configuration");

endmodule

// File: tb/sim_tick_prescaler_tree.sv
module sim_tick_prescaler_tree;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic [1:0]  ext_clk = '0;
    logic [4:0]  tick;

    int n_chk = 0;
    int n_bad = 0;
    int dbl_cnt = 0;
    logic [4:0] prev_tick = '0;
    bit counting = 1'b0;
    int tcount [5];

    always #2 clk = ~clk;

    tick_prescaler_tree u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if ((tick & prev_tick) != 0 && !wr_en) dbl_cnt++;
            prev_tick <= tick;
            if (counting)
                for (int i = 0; i < 5; i++) tcount[i] += int'(tick[i]);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [19:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic first_tick(input int ch, output int k);
        k = 1;
        while (!tick[ch] && k < 5000) begin @(negedge clk); k++; end
    endtask

    task automatic period(input int ch, output int p);
        int g = 0;
        while (!tick[ch] && g < 5000) begin @(negedge clk); g++; end
        @(negedge clk);
        p = 1;
        while (!tick[ch] && p < 5000) begin @(negedge clk); p++; end
    endtask

    task automatic chk_period(input string req, input int ch, input int exp);
        int p;
        period(ch, p);
        check(req, $sformatf("ch%0d period", ch), p, exp);
    endtask

    task automatic ext_edges(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk[idx] = 1'b1; repeat (4) @(negedge clk);
            ext_clk[idx] = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 5; i++) tcount[i] = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "ticks during reset", int'(tick), 0);
        rst = 1'b0;
        for (int c = 0; c < 5; c++) chk_period("R1", c, 2);
    endtask

    task automatic t_prescale();
        int k;
        wr(0, 20'h0_0903);
        first_tick(0, k);
        check("R7", "first tick after prescaler write", k, 8);
        chk_period("R2", 0, 8);
        chk_period("R3", 1, 8);
        chk_period("R3", 2, 20);
        chk_period("R3", 3, 20);
        wr(0, 20'h0_00FF);
        chk_period("R2", 0, 512);
        chk_period("R3", 2, 2);
    endtask

    task automatic t_divider();
        wr(0, 20'h0);
        wr(1, 20'h13210);
        chk_period("R4", 0, 2);
        chk_period("R4", 1, 4);
        chk_period("R4", 2, 8);
        chk_period("R4", 3, 16);
        chk_period("R4", 4, 4);
        wr(0, 20'h0_0400);
        chk_period("R2", 3, 80);
        chk_period("R3", 0, 2);
    endtask

    task automatic t_single();
        int k;
        wr(0, 20'h0);
        wr(1, 20'h13210);
        wr(2 + 3, 20'h0);
        first_tick(3, k);
        check("R8", "ch3 first tick after field write", k, 2);
        chk_period("R6", 3, 2);
        chk_period("R6", 2, 8);
        chk_period("R6", 4, 4);
        chk_period("R6", 1, 4);
        wr(2 + 1, 20'h3);
        first_tick(1, k);
        check("R8", "ch1 first tick after field write", k, 16);
        chk_period("R6", 1, 16);
        chk_period("R6", 0, 2);
        wr(2 + 0, 20'hFFFF1);
        chk_period("R6", 0, 4);
        chk_period("R6", 1, 16);
    endtask

    task automatic t_ext();
        wr(0, 20'h0_0505);
        wr(1, 20'h18F04);
        clear_counts();
        counting = 1'b1;
        ext_edges(0, 5);
        repeat (6) @(negedge clk);
        counting = 1'b0;
        check("R5", "ch0 ticks from input 0", tcount[0], 5);
        check("R5", "ch2 ticks during input 0", tcount[2], 0);
        clear_counts();
        counting = 1'b1;
        ext_edges(1, 3);
        repeat (6) @(negedge clk);
        counting = 1'b0;
        check("R5", "ch0 ticks during input 1", tcount[0], 0);
        check("R5", "ch2 ticks from input 1", tcount[2], 3);
        check("R5", "ch3 ticks from input 1", tcount[3], 3);
        chk_period("R4", 4, 24);
    endtask

    task automatic t_unmapped();
        wr(0, 20'h0);
        wr(1, 20'h13210);
        wr(7, 20'hFFFFF);
        chk_period("R10", 0, 2);
        chk_period("R10", 3, 16);
        chk_period("R10", 2, 8);
    endtask

    initial begin
        t_reset();
        t_prescale();
        t_divider();
        t_single();
        t_ext();
        t_unmapped();
        check("R9", "back-to-back ticks", dbl_cnt, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule